// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-node directory for a group of memory blocks in a distributed shared-memory system. For each block it keeps a coherence state: Uncached, Shared or Exclusive. It also keeps a sharer vector with one bit per processor and the ID of the owning processor. It takes coherence requests from a single ordered input channel: read misses, write misses and data write-backs. It answers on a single output channel with invalidates, fetches, fetch-with-invalidates and data value replies, one message per cycle.

Some requests need several messages. A write miss to a Shared block first sends an invalidate to each other sharer, in ascending ID order, and only then replies. A miss to an Exclusive block sends a fetch or fetch/invalidate to the owner. The controller then waits for that owner's write-back before it replies. While it waits, it holds the input channel by keeping `req_ready` low for every message except the awaited write-back.

The directory storage is a synchronous-read array that can map to block RAM. A reset clears a per-block valid vector, so every block starts Uncached.

Top module: `coh_home_dir`

## Requirements
- R1: After reset, `out_valid` is 0, `req_ready` is 1, and every block behaves as Uncached.
- R2: A read miss (`req_type`=0) to an Uncached block produces one data value reply (`out_type`=3) to the requester. The block becomes Shared with the requester as its only sharer. The controller takes no new request during the lookup cycle.
- R3: A write miss (`req_type`=1) to an Uncached block produces one data value reply to the requester. The block becomes Exclusive with the requester as owner and sole sharer.
- R4: A read miss to a Shared block produces one data value reply and adds the requester to the existing sharers.
- R5: A write miss to a Shared block first sends an invalidate (`out_type`=0) to every sharer other than the requester. These go out one per cycle in ascending processor ID, and the data value reply follows in the next cycle. The block becomes Exclusive owned by the requester.
- R6: A read miss to an Exclusive block sends a fetch (`out_type`=1) to the owner and waits. After the owner's write-back is accepted, it replies to the requester, and the block becomes Shared with the old owner and the requester as sharers.
- R7: A write miss to an Exclusive block sends a fetch/invalidate (`out_type`=2) to the owner and waits. After the owner's write-back, it replies to the requester, and the block stays Exclusive with the requester as the new owner and sole sharer.
- R8: A write-back (`req_type`=2) from the owner of an Exclusive block produces no message and makes the block Uncached with an empty sharer set.
- R9: A write-back to a block that is not Exclusive, or from a processor that is not its owner, produces no message and leaves the block unchanged. A `req_type` of 3 is ignored in the same way.
- R10: While waiting for an owner's write-back, `req_ready` is 0 for every other request and no message is sent. Held requests stay in order at the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Incoming request present |
| req_ready | output | 1 | Request accepted at this clock edge when high together with req_valid |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 data write-back |
| req_src | input | IDW | Sending processor ID |
| req_addr | input | AW | Memory block index |
| out_valid | output | 1 | Outgoing message present for one cycle |
| out_type | output | 2 | 0 invalidate, 1 fetch, 2 fetch/invalidate, 3 data value reply |
| out_dest | output | IDW | Destination processor ID |
| out_addr | output | AW | Memory block index of the message |

## Verification
A request is accepted at a clock edge, and its first message appears after the next edge. When a write miss needs k invalidates, they appear after edges 1 to k and the reply after edge k+1. The reply that closes a fetch appears after the same edge that accepts the owner's write-back. Write-backs give no message at all. The bench drives inputs on the falling edge and compares `out_valid`, `out_type`, `out_dest` and `out_addr` on each falling edge against the list that its own directory model predicts. After the last expected message it checks for one silent cycle with `req_ready` high. This confirms that nothing extra was sent and that the state change is visible through the replies to later requests.

// File: rtl/coh_pkg.sv
package coh_pkg;
  // request kinds on the input channel
  localparam logic [1:0] REQ_RD = 2'd0;
  localparam logic [1:0] REQ_WR = 2'd1;
  localparam logic [1:0] REQ_WB = 2'd2;
  // message kinds on the output channel
  localparam logic [1:0] MSG_INV  = 2'd0;
  localparam logic [1:0] MSG_FET  = 2'd1;
  localparam logic [1:0] MSG_FINV = 2'd2;
  localparam logic [1:0] MSG_DATA = 2'd3;
  // per-block coherence state
  localparam logic [1:0] DS_UNC = 2'd0;
  localparam logic [1:0] DS_SHR = 2'd1;
  localparam logic [1:0] DS_EXC = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_INV  = 2'd2,
    ST_WAIT = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/coh_dir_store.sv
module coh_dir_store #(
  parameter int NBLK  = 16,
  parameter int NPROC = 4,
  localparam int IDW = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int AW  = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int EW  = 2 + NPROC + IDW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    rd_addr,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [1:0]       wr_state,
  input  logic [NPROC-1:0] wr_sharers,
  input  logic [IDW-1:0]   wr_owner,
  output logic [1:0]       rd_state,
  output logic [NPROC-1:0] rd_sharers,
  output logic [IDW-1:0]   rd_owner
);
  import coh_pkg::*;

  logic [EW-1:0]   mem [NBLK];
  logic [EW-1:0]   rd_word_q;
  logic [NBLK-1:0] vld_q;
  logic            rd_vld_q;

  // storage array without reset so it can map to block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= {wr_state, wr_sharers, wr_owner};
    rd_word_q <= mem[rd_addr];
  end

  // valid vector marks blocks written since reset
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      if (wr_en) vld_q[wr_addr] <= 1'b1;
      rd_vld_q <= vld_q[rd_addr];
    end
  end

  always_comb begin
    if (rd_vld_q) begin
      {rd_state, rd_sharers, rd_owner} = rd_word_q;
    end else begin
      rd_state   = DS_UNC;
      rd_sharers = '0;
      rd_owner   = '0;
    end
  end
endmodule

// File: rtl/coh_low_pick.sv
module coh_low_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt[i]    = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir #(
  parameter int NPROC = 4,
  parameter int NBLK  = 16,
  localparam int IDW = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int AW  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [1:0]     req_type,
  input  logic [IDW-1:0] req_src,
  input  logic [AW-1:0]  req_addr,
  output logic           out_valid,
  output logic [1:0]     out_type,
  output logic [IDW-1:0] out_dest,
  output logic [AW-1:0]  out_addr
);
  import coh_pkg::*;

  ctl_state_e       st_q;
  logic [1:0]       r_type;
  logic [IDW-1:0]   r_src;
  logic [AW-1:0]    r_addr;
  logic [IDW-1:0]   cur_own;
  logic [NPROC-1:0] pend_q;

  logic [1:0]       rd_st;
  logic [NPROC-1:0] rd_sh;
  logic [IDW-1:0]   rd_own;

  logic             wr_en;
  logic [1:0]       wr_st;
  logic [NPROC-1:0] wr_sh;
  logic [IDW-1:0]   wr_own;

  logic [NPROC-1:0] src_oh, own_oh, inv_mask, pick_in, pick_gnt;
  logic [IDW-1:0]   pick_idx;
  logic             pick_any;
  logic             wb_match;
  logic             in_idle, in_wait;

  coh_dir_store #(.NBLK(NBLK), .NPROC(NPROC)) store_i (
    .clk(clk), .rst(rst), .rd_addr(req_addr),
    .wr_en(wr_en), .wr_addr(r_addr), .wr_state(wr_st),
    .wr_sharers(wr_sh), .wr_owner(wr_own),
    .rd_state(rd_st), .rd_sharers(rd_sh), .rd_owner(rd_own)
  );

  coh_low_pick #(.N(NPROC)) pick_i (
    .req(pick_in), .gnt(pick_gnt), .idx(pick_idx), .any(pick_any)
  );

  assign in_idle  = (st_q == ST_IDLE);
  assign in_wait  = (st_q == ST_WAIT);
  assign src_oh   = NPROC'(1) << r_src;
  assign own_oh   = NPROC'(1) << cur_own;
  assign inv_mask = rd_sh & ~src_oh;
  assign pick_in  = (st_q == ST_LOOK) ? inv_mask : pend_q;
  assign wb_match = req_valid && (req_type == REQ_WB) &&
                    (req_addr == r_addr) && (req_src == cur_own);
  assign req_ready = in_idle || (in_wait && wb_match);

  // directory write port: next entry for the block under service
  always_comb begin
    wr_en  = 1'b0;
    wr_st  = DS_UNC;
    wr_sh  = '0;
    wr_own = r_src;
    case (st_q)
      ST_LOOK: begin
        if (r_type == REQ_RD) begin
          if (rd_st == DS_UNC) begin
            wr_en = 1'b1; wr_st = DS_SHR; wr_sh = src_oh;
          end else if (rd_st == DS_SHR) begin
            wr_en = 1'b1; wr_st = DS_SHR; wr_sh = rd_sh | src_oh;
          end
        end else if (r_type == REQ_WR) begin
          if (rd_st == DS_UNC || (rd_st == DS_SHR && !pick_any)) begin
            wr_en = 1'b1; wr_st = DS_EXC; wr_sh = src_oh;
          end
        end else if (r_type == REQ_WB) begin
          if (rd_st == DS_EXC && rd_own == r_src) begin
            wr_en = 1'b1; wr_st = DS_UNC; wr_sh = '0;
          end
        end
      end
      ST_INV: begin
        if (pend_q == '0) begin
          wr_en = 1'b1; wr_st = DS_EXC; wr_sh = src_oh;
        end
      end
      ST_WAIT: begin
        if (wb_match) begin
          wr_en = 1'b1;
          if (r_type == REQ_RD) begin
            wr_st = DS_SHR; wr_sh = src_oh | own_oh;
          end else begin
            wr_st = DS_EXC; wr_sh = src_oh;
          end
        end
      end
      default: ;
    endcase
  end

  // sequencer with registered message outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      r_type    <= '0;
      r_src     <= '0;
      r_addr    <= '0;
      cur_own   <= '0;
      pend_q    <= '0;
      out_valid <= 1'b0;
      out_type  <= '0;
      out_dest  <= '0;
      out_addr  <= '0;
    end else begin
      out_valid <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            r_type <= req_type;
            r_src  <= req_src;
            r_addr <= req_addr;
            st_q   <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          cur_own  <= rd_own;
          out_addr <= r_addr;
          st_q     <= ST_IDLE;
          if (r_type == REQ_RD || r_type == REQ_WR) begin
            out_valid <= 1'b1;
            if (rd_st == DS_EXC) begin
              out_type <= (r_type == REQ_RD) ? MSG_FET : MSG_FINV;
              out_dest <= rd_own;
              st_q     <= ST_WAIT;
            end else if (r_type == REQ_WR && rd_st == DS_SHR && pick_any) begin
              out_type <= MSG_INV;
              out_dest <= pick_idx;
              pend_q   <= inv_mask & ~pick_gnt;
              st_q     <= ST_INV;
            end else begin
              out_type <= MSG_DATA;
              out_dest <= r_src;
            end
          end
        end
        ST_INV: begin
          out_valid <= 1'b1;
          out_addr  <= r_addr;
          if (pick_any) begin
            out_type <= MSG_INV;
            out_dest <= pick_idx;
            pend_q   <= pend_q & ~pick_gnt;
          end else begin
            out_type <= MSG_DATA;
            out_dest <= r_src;
            st_q     <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (wb_match) begin
            out_valid <= 1'b1;
            out_type  <= MSG_DATA;
            out_dest  <= r_src;
            out_addr  <= r_addr;
            st_q      <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coh_home_dir_chk.sv
module coh_home_dir_chk #(
  parameter int IDW = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic           req_ready,
  input logic [1:0]     req_type,
  input logic           out_valid,
  input logic [1:0]     out_type,
  input logic [IDW-1:0] out_dest,
  input logic           in_idle,
  input logic           in_wait
);
  // R1: first cycle out of reset is quiet and ready
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && req_ready));

  // R2: an accepted request blocks the channel during its lookup
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (in_idle && req_valid && req_ready) |=> !req_ready);

  // R5: back-to-back invalidates go to rising processor IDs
  p_inv_ascend_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_type == 2'd0 && $past(out_valid && out_type == 2'd0))
      |-> (out_dest > $past(out_dest)));

  // R6/R7: a fetch is followed by silence or the closing reply
  p_fetch_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_type == 2'd1 || out_type == 2'd2))
      |=> (!out_valid || out_type == 2'd3));

  // R8: a write-back never produces a message
  p_wb_silent_r8: assert property (@(posedge clk) disable iff (rst)
    (in_idle && req_valid && req_ready && req_type == 2'd2) |=> ##1 !out_valid);

  // R10: only the awaited write-back may enter while waiting
  p_wait_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (in_wait && req_valid && req_type != 2'd2) |-> !req_ready);

  // R10: no message while waiting without the write-back
  p_wait_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (in_wait && !(req_valid && req_ready)) |=> !out_valid);
endmodule

bind coh_home_dir coh_home_dir_chk #(.IDW(IDW)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_type(req_type), .out_valid(out_valid), .out_type(out_type),
  .out_dest(out_dest), .in_idle(in_idle), .in_wait(in_wait)
);

// File: tb/coh_home_dir_tb.sv
module coh_home_dir_tb_top;
  localparam int NPROC = 4;
  localparam int NBLK  = 16;
  localparam int IDW   = 2;
  localparam int AW    = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic [1:0]     req_type = '0;
  logic [IDW-1:0] req_src = '0;
  logic [AW-1:0]  req_addr = '0;
  logic           out_valid;
  logic [1:0]     out_type;
  logic [IDW-1:0] out_dest;
  logic [AW-1:0]  out_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model of the directory: 0 Uncached, 1 Shared, 2 Exclusive
  int              m_st  [NBLK];
  logic [NPROC-1:0] m_sh [NBLK];
  int              m_own [NBLK];

  always #2 clk = ~clk;

  coh_home_dir #(.NPROC(NPROC), .NBLK(NBLK)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_src(req_src), .req_addr(req_addr),
    .out_valid(out_valid), .out_type(out_type), .out_dest(out_dest),
    .out_addr(out_addr)
  );

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check_msg(string tag, int ty, int dest, int addr);
    checks++;
    if (out_valid !== 1'b1 || int'(out_type) != ty ||
        int'(out_dest) != dest || int'(out_addr) != addr) begin
      failures++;
      $display("FAIL %s: actual v=%0b t=%0d d=%0d a=%0d expected v=1 t=%0d d=%0d a=%0d",
               tag, out_valid, out_type, out_dest, out_addr, ty, dest, addr);
    end
  endtask

  // one request, checked message by message against the model
  task automatic do_req(int t, int src, int addr);
    int st = m_st[addr];
    logic [NPROC-1:0] sh = m_sh[addr];
    int own = m_own[addr];
    string tag;
    @(negedge clk);
    req_valid = 1'b1; req_type = 2'(t); req_src = IDW'(src); req_addr = AW'(addr);
    #0.1;
    check_bit("R1 ready in idle", req_ready, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    check_bit("R2 quiet during lookup", out_valid, 1'b0);
    if (t == 0 && st != 2) begin
      tag = (st == 0) ? "R2 read uncached" : "R4 read shared";
      @(negedge clk); check_msg(tag, 3, src, addr);
      m_st[addr] = 1;
      m_sh[addr] = sh | (NPROC'(1) << src);
    end else if (t == 1 && st != 2) begin
      if (st == 1) begin
        for (int i = 0; i < NPROC; i++) begin
          if (sh[i] && i != src) begin
            @(negedge clk); check_msg("R5 invalidate", 0, i, addr);
          end
        end
      end
      tag = (st == 0) ? "R3 write uncached" : "R5 reply after invalidates";
      @(negedge clk); check_msg(tag, 3, src, addr);
      m_st[addr] = 2; m_sh[addr] = NPROC'(1) << src; m_own[addr] = src;
    end else if (t != 2 && st == 2) begin
      tag = (t == 0) ? "R6 fetch" : "R7 fetch-invalidate";
      @(negedge clk); check_msg(tag, (t == 0) ? 1 : 2, own, addr);
      // unrelated request must be held back
      req_valid = 1'b1; req_type = 2'd0; req_src = IDW'((own + 1) % NPROC); req_addr = AW'(addr);
      @(negedge clk);
      check_bit("R10 held while waiting", req_ready, 1'b0);
      check_bit("R10 silent while waiting", out_valid, 1'b0);
      req_type = 2'd2; req_src = IDW'(own);
      #0.1;
      check_bit("R10 owner write-back accepted", req_ready, 1'b1);
      @(negedge clk);
      req_valid = 1'b0;
      tag = (t == 0) ? "R6 reply after write-back" : "R7 reply after write-back";
      check_msg(tag, 3, src, addr);
      if (t == 0) begin
        m_st[addr] = 1; m_sh[addr] = (NPROC'(1) << src) | (NPROC'(1) << own);
      end else begin
        m_st[addr] = 2; m_sh[addr] = NPROC'(1) << src; m_own[addr] = src;
      end
    end else begin
      if (st == 2 && own == src) begin
        m_st[addr] = 0; m_sh[addr] = '0;
      end
    end
    @(negedge clk);
    tag = (t == 2) ? ((st == 2 && own == src) ? "R8 write-back silent" : "R9 stray write-back silent")
                   : "R2 no extra message";
    check_bit(tag, out_valid, 1'b0);
    check_bit("R10 ready after transaction", req_ready, 1'b1);
  endtask

  initial begin
    for (int b = 0; b < NBLK; b++) begin
      m_st[b] = 0; m_sh[b] = '0; m_own[b] = 0;
    end
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check_bit("R1 out_valid after reset", out_valid, 1'b0);
    check_bit("R1 ready after reset", req_ready, 1'b1);
    // directed walk through every transition on one block
    do_req(0, 0, 5);
    do_req(0, 2, 5);
    do_req(0, 3, 5);
    do_req(1, 2, 5);
    do_req(0, 1, 5);
    do_req(1, 3, 5);
    do_req(1, 0, 5);
    do_req(2, 1, 5);
    do_req(2, 0, 5);
    do_req(0, 1, 5);
    do_req(1, 3, 7);
    do_req(2, 2, 9);
    do_req(3, 1, 9);
    do_req(1, 0, 9);
    do_req(0, 3, 15);
    do_req(0, 0, 15);
    do_req(0, 1, 15);
    do_req(0, 2, 15);
    do_req(1, 3, 15);
    // random traffic over a few blocks to force conflicts
    for (int n = 0; n < 400; n++) begin
      int a = int'($urandom % 4);
      int t = int'($urandom % 3);
      int s = int'($urandom % NPROC);
      if (t == 2 && m_st[a] == 2 && ($urandom % 2) == 0) s = m_own[a];
      do_req(t, s, a);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule